// File: doc/BRIEF.md
# Effective Address Generation Unit

This block forms the operand address of a load or store. It combines up to three terms: a base register, an index register that can be scaled, and a signed displacement. It has two schemes, selected per request. In the wide scheme any of the eight registers may be the base. The index is shifted left by 0 to 3 places, so it is multiplied by 1, 2, 4 or 8. In the narrow scheme the base must come from a fixed pair, the index must come from a second fixed pair, and the result wraps at 16 bits. A combine-mode input can merge the base and index terms with a bitwise OR instead of an add; the displacement is always added afterwards.

The block does not store register contents. It drives the two register selects straight to an external register-file read port, and the values return in the same cycle. A request is taken on a valid/ready input handshake. The address and an illegal-encoding flag leave through a single registered valid/ready stage.

Back-pressure works like this. `in_ready` is high whenever the output stage is empty, or is being emptied in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output payload stays frozen, `in_ready` stays low, and a new request waits. An accepted request's result is presented in the next cycle.

Top module: `eag_top`

## Requirements
- R1: When `mode_wide`=1, `out_addr` = base + (index << `scale_sh`) + displacement, modulo 2^32. Carries out of bit 31 are lost, and any of the eight register codes 0..7 may be the base.
- R2: When `mode_wide`=1 and `idx_en`=1, index code 4 (the stack pointer) is illegal. The result is `out_illegal`=1 and `out_addr`=0.
- R3: When `mode_wide`=1, `scale_sh` values 0, 1, 2 and 3 multiply the index term by 1, 2, 4 and 8.
- R4: When `mode_wide`=0 and both registers are enabled, the base code must be 3 or 5 and the index code must be 6 or 7. When only one register is enabled, its code must be one of 3, 5, 6 or 7. Any other case gives `out_illegal`=1 and `out_addr`=0, and `scale_sh` has no effect in this mode.
- R5: When `mode_wide`=0, the address is the sum modulo 2^16. Bits 31:16 of `out_addr` are zero, and only the low 16 bits of the register values affect the result.
- R6: When `or_combine`=1, the base term and the (scaled) index term are merged with a bitwise OR, and the displacement is then added. When `or_combine`=0, the two terms are added.
- R7: When `disp_wide`=0, the displacement is `disp[7:0]` sign-extended and bits 31:8 of `disp` are ignored. When `disp_wide`=1, all 32 bits of `disp` are used.
- R8: `idx_en`=0 removes the index term, so `idx_sel` and `scale_sh` are ignored. `base_en`=0 removes the base term. With neither enabled, the address is the displacement alone.
- R9: `in_ready` = !`out_valid` || `out_ready`. While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_addr` and `out_illegal` hold their values.
- R10: A request accepted at a clock edge (`in_valid` && `in_ready`) appears on `out_valid`/`out_addr`/`out_illegal` right after that edge.
- R11: After reset, `out_valid`, `out_addr` and `out_illegal` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| mode_wide | input | 1 | 1 = wide (32-bit) scheme, 0 = narrow (16-bit) scheme |
| or_combine | input | 1 | 1 = OR base and index terms, 0 = add them |
| base_en | input | 1 | Base term present |
| base_sel | input | 3 | Base register code |
| idx_en | input | 1 | Index term present |
| idx_sel | input | 3 | Index register code |
| scale_sh | input | 2 | Index left-shift amount (wide scheme) |
| disp | input | 32 | Displacement |
| disp_wide | input | 1 | 1 = 32-bit displacement, 0 = sign-extended low byte |
| rf_base_sel | output | 3 | Register-file read select for the base |
| rf_idx_sel | output | 3 | Register-file read select for the index |
| rf_base_val | input | 32 | Base register value returned this cycle |
| rf_idx_val | input | 32 | Index register value returned this cycle |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_addr | output | 32 | Effective address (0 when illegal) |
| out_illegal | output | 1 | Illegal register or pairing encoding |

## Verification
Every result, including the illegal flag, is due exactly one clock edge after the edge that accepts its request. The register-file values are sampled at that accepting edge.

The bench changes inputs on falling edges and compares outputs on the next falling edge, so each comparison lands after the single register stage and before the following edge. Requests are issued back to back, one per cycle, so every falling edge both checks the previous vector and applies the next one.

In the stall sequence, each hold cycle is checked on its own falling edge. The waiting request is then expected one edge after `out_ready` rises.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int ADDR_W       = 32;
  localparam int NARROW_W     = 16;
  localparam int SHORT_DISP_W = 8;
  localparam int NUM_REGS     = 8;
  localparam int SCALE_W      = 2;
  localparam int SP_CODE      = 4;
  localparam int NB_BASE_A    = 3;
  localparam int NB_BASE_B    = 5;
  localparam int NB_IDX_A     = 6;
  localparam int NB_IDX_B     = 7;

  typedef enum logic {MODE_NARROW = 1'b0, MODE_WIDE = 1'b1} addr_mode_e;
  typedef enum logic {COMB_ADD = 1'b0, COMB_OR = 1'b1} comb_op_e;
endpackage

// File: rtl/eag_legal.sv
module eag_legal #(
  parameter int RIW    = 3,
  parameter int SP     = 4,
  parameter int BASE_A = 3,
  parameter int BASE_B = 5,
  parameter int IDX_A  = 6,
  parameter int IDX_B  = 7
) (
  input  eag_pkg::addr_mode_e mode,
  input  logic                base_en,
  input  logic                idx_en,
  input  logic [RIW-1:0]      base_sel,
  input  logic [RIW-1:0]      idx_sel,
  output logic                illegal
);
  localparam logic [RIW-1:0] SP_C = RIW'(SP);
  localparam logic [RIW-1:0] BA_C = RIW'(BASE_A);
  localparam logic [RIW-1:0] BB_C = RIW'(BASE_B);
  localparam logic [RIW-1:0] IA_C = RIW'(IDX_A);
  localparam logic [RIW-1:0] IB_C = RIW'(IDX_B);

  logic base_bpair, base_ipair, idx_bpair, idx_ipair;
  logic wide_bad, narrow_bad;

  // membership of each select in the two fixed narrow-scheme pairs
  assign base_bpair = (base_sel == BA_C) || (base_sel == BB_C);
  assign base_ipair = (base_sel == IA_C) || (base_sel == IB_C);
  assign idx_bpair  = (idx_sel == BA_C) || (idx_sel == BB_C);
  assign idx_ipair  = (idx_sel == IA_C) || (idx_sel == IB_C);

  always_comb begin
    wide_bad = idx_en && (idx_sel == SP_C);
    unique case ({base_en, idx_en})
      2'b11:   narrow_bad = !(base_bpair && idx_ipair);
      2'b10:   narrow_bad = !(base_bpair || base_ipair);
      2'b01:   narrow_bad = !(idx_bpair || idx_ipair);
      default: narrow_bad = 1'b0;
    endcase
    illegal = (mode == eag_pkg::MODE_WIDE) ? wide_bad : narrow_bad;
  end
endmodule

// File: rtl/eag_terms.sv
module eag_terms #(
  parameter int AW  = 32,
  parameter int SDW = 8,
  parameter int SCW = 2
) (
  input  eag_pkg::addr_mode_e mode,
  input  logic                base_en,
  input  logic                idx_en,
  input  logic                disp_wide,
  input  logic [SCW-1:0]      scale_sh,
  input  logic [AW-1:0]       base_val,
  input  logic [AW-1:0]       idx_val,
  input  logic [AW-1:0]       disp,
  output logic [AW-1:0]       base_term,
  output logic [AW-1:0]       idx_term,
  output logic [AW-1:0]       disp_term
);
  localparam int NSC = 1 << SCW;

  logic [AW-1:0]  scaled [NSC];
  logic [SCW-1:0] eff_sh;
  logic [AW-1:0]  disp_short;

  // one pre-shifted copy of the index per scale step
  for (genvar s = 0; s < NSC; s++) begin : g_scale
    assign scaled[s] = idx_val << s;
  end

  // scaling only exists in the wide scheme
  assign eff_sh    = (mode == eag_pkg::MODE_WIDE) ? scale_sh : '0;
  assign idx_term  = idx_en ? scaled[eff_sh] : '0;
  assign base_term = base_en ? base_val : '0;

  if (SDW < AW) begin : g_sext
    assign disp_short = {{(AW-SDW){disp[SDW-1]}}, disp[SDW-1:0]};
  end else begin : g_full
    assign disp_short = disp;
  end

  assign disp_term = disp_wide ? disp : disp_short;
endmodule

// File: rtl/eag_combine.sv
module eag_combine #(
  parameter int AW = 32,
  parameter int NW = 16
) (
  input  eag_pkg::comb_op_e   op,
  input  eag_pkg::addr_mode_e mode,
  input  logic                illegal,
  input  logic [AW-1:0]       base_term,
  input  logic [AW-1:0]       idx_term,
  input  logic [AW-1:0]       disp_term,
  output logic [AW-1:0]       addr
);
  logic [AW-1:0] merged, total, narrow_mask;

  if (NW < AW) begin : g_mask
    assign narrow_mask = {{(AW-NW){1'b0}}, {NW{1'b1}}};
  end else begin : g_nomask
    assign narrow_mask = '1;
  end

  always_comb begin
    merged = (op == eag_pkg::COMB_OR) ? (base_term | idx_term)
                                      : (base_term + idx_term);
    total  = merged + disp_term;
    if (illegal)
      addr = '0;
    else if (mode == eag_pkg::MODE_WIDE)
      addr = total;
    else
      addr = total & narrow_mask;
  end
endmodule

// File: rtl/eag_outreg.sv
module eag_outreg #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);  // R10
  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));  // R9
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);  // R9
endmodule

// File: rtl/eag_top.sv
module eag_top #(
  parameter int AW       = eag_pkg::ADDR_W,
  parameter int NW       = eag_pkg::NARROW_W,
  parameter int SDW      = eag_pkg::SHORT_DISP_W,
  parameter int NREGS    = eag_pkg::NUM_REGS,
  parameter int SCW      = eag_pkg::SCALE_W,
  parameter int SP       = eag_pkg::SP_CODE,
  parameter int BASE_A   = eag_pkg::NB_BASE_A,
  parameter int BASE_B   = eag_pkg::NB_BASE_B,
  parameter int IDX_A    = eag_pkg::NB_IDX_A,
  parameter int IDX_B    = eag_pkg::NB_IDX_B,
  localparam int RIW     = $clog2(NREGS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic           mode_wide,
  input  logic           or_combine,
  input  logic           base_en,
  input  logic [RIW-1:0] base_sel,
  input  logic           idx_en,
  input  logic [RIW-1:0] idx_sel,
  input  logic [SCW-1:0] scale_sh,
  input  logic [AW-1:0]  disp,
  input  logic           disp_wide,
  output logic [RIW-1:0] rf_base_sel,
  output logic [RIW-1:0] rf_idx_sel,
  input  logic [AW-1:0]  rf_base_val,
  input  logic [AW-1:0]  rf_idx_val,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [AW-1:0]  out_addr,
  output logic           out_illegal
);
  localparam logic [RIW-1:0] SP_C = RIW'(SP);
  localparam logic [RIW-1:0] BA_C = RIW'(BASE_A);
  localparam logic [RIW-1:0] BB_C = RIW'(BASE_B);

  eag_pkg::addr_mode_e mode;
  eag_pkg::comb_op_e   op;
  logic                illegal;
  logic [AW-1:0]       base_term, idx_term, disp_term, addr_c;
  logic [AW:0]         out_payload;
  logic                in_fire;

  assign mode        = eag_pkg::addr_mode_e'(mode_wide);
  assign op          = eag_pkg::comb_op_e'(or_combine);
  assign rf_base_sel = base_sel;
  assign rf_idx_sel  = idx_sel;
  assign in_fire     = in_valid && in_ready;

  eag_legal #(.RIW(RIW), .SP(SP), .BASE_A(BASE_A), .BASE_B(BASE_B),
              .IDX_A(IDX_A), .IDX_B(IDX_B)) u_legal (
    .mode(mode), .base_en(base_en), .idx_en(idx_en),
    .base_sel(base_sel), .idx_sel(idx_sel), .illegal(illegal));

  eag_terms #(.AW(AW), .SDW(SDW), .SCW(SCW)) u_terms (
    .mode(mode), .base_en(base_en), .idx_en(idx_en), .disp_wide(disp_wide),
    .scale_sh(scale_sh), .base_val(rf_base_val), .idx_val(rf_idx_val),
    .disp(disp), .base_term(base_term), .idx_term(idx_term),
    .disp_term(disp_term));

  eag_combine #(.AW(AW), .NW(NW)) u_combine (
    .op(op), .mode(mode), .illegal(illegal), .base_term(base_term),
    .idx_term(idx_term), .disp_term(disp_term), .addr(addr_c));

  eag_outreg #(.W(AW+1)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data({illegal, addr_c}), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_payload));

  assign out_illegal = out_payload[AW];
  assign out_addr    = out_payload[AW-1:0];

  AST_SP_INDEX_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && mode_wide && idx_en && idx_sel == SP_C)
      |=> (out_illegal && out_addr == '0));  // R2
  AST_NARROW_BAD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !mode_wide && base_en && idx_en &&
     !(base_sel == BA_C || base_sel == BB_C)) |=> out_illegal);  // R4
  AST_ILLEGAL_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_addr == '0));  // R4
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !mode_wide) |=> (out_addr[AW-1:NW] == '0));  // R5
endmodule

// File: tb/tb_eag_top.sv
module tb_eag_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic        mode_wide = 1'b0, or_combine = 1'b0, base_en = 1'b0, idx_en = 1'b0;
  logic [2:0]  base_sel = '0, idx_sel = '0, rf_base_sel, rf_idx_sel;
  logic [1:0]  scale_sh = '0;
  logic [31:0] disp = '0;
  logic        disp_wide = 1'b0;
  logic [31:0] rf_base_val, rf_idx_val;
  logic        out_valid, out_ready = 1'b1, out_illegal;
  logic [31:0] out_addr;
  logic [31:0] rf [8];

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign rf_base_val = rf[rf_base_sel];
  assign rf_idx_val  = rf[rf_idx_sel];

  eag_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mode_wide(mode_wide), .or_combine(or_combine), .base_en(base_en),
    .base_sel(base_sel), .idx_en(idx_en), .idx_sel(idx_sel),
    .scale_sh(scale_sh), .disp(disp), .disp_wide(disp_wide),
    .rf_base_sel(rf_base_sel), .rf_idx_sel(rf_idx_sel),
    .rf_base_val(rf_base_val), .rf_idx_val(rf_idx_val),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_illegal(out_illegal));

  function automatic logic [31:0] mix(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] h;
    h = a * 32'h9E3779B1 + b * 32'h7F4A7C15 + 32'h1234567;
    h = h ^ (h >> 15);
    h = h * 32'h2C1B3C6D;
    h = h ^ (h >> 12);
    return h;
  endfunction

  function automatic logic in4(input logic [2:0] c);
    return (c == 3) || (c == 5) || (c == 6) || (c == 7);
  endfunction

  // expected {illegal, addr} from the requirement text
  function automatic logic [32:0] model();
    logic        bad;
    logic [31:0] bt, xt, cm, d, sum;
    if (mode_wide) bad = idx_en && (idx_sel == 3'd4);
    else if (base_en && idx_en)
      bad = !(((base_sel == 3) || (base_sel == 5)) && ((idx_sel == 6) || (idx_sel == 7)));
    else if (base_en) bad = !in4(base_sel);
    else if (idx_en)  bad = !in4(idx_sel);
    else bad = 1'b0;
    bt  = base_en ? rf[base_sel] : 32'd0;
    xt  = idx_en ? (mode_wide ? (rf[idx_sel] << scale_sh) : rf[idx_sel]) : 32'd0;
    cm  = or_combine ? (bt | xt) : (bt + xt);
    d   = disp_wide ? disp : {{24{disp[7]}}, disp[7:0]};
    sum = cm + d;
    if (!mode_wide) sum = sum & 32'h0000FFFF;
    if (bad) sum = 32'd0;
    return {bad, sum};
  endfunction

  function automatic string pick_tag(input logic [32:0] e);
    if (e[32])                       return mode_wide ? "R2" : "R4";
    if (or_combine)                  return "R6";
    if (!mode_wide)                  return "R5";
    if (!idx_en || !base_en)         return "R8";
    if (scale_sh != 2'd0)            return "R3";
    if (!disp_wide)                  return "R7";
    return "R1";
  endfunction

  task automatic chk(input string tag, input logic [33:0] got, input logic [33:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got valid=%0b illegal=%0b addr=%h expected valid=%0b illegal=%0b addr=%h",
               tag, got[33], got[32], got[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic drive(input logic m, input logic o, input logic be, input logic [2:0] bs,
                       input logic ie, input logic [2:0] is, input logic [1:0] sc,
                       input logic dw, input logic [31:0] d);
    mode_wide = m; or_combine = o; base_en = be; base_sel = bs;
    idx_en = ie; idx_sel = is; scale_sh = sc; disp_wide = dw; disp = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [32:0] prev_exp, exp_a, exp_b;
    string       prev_tag;
    for (int k = 0; k < 8; k++) rf[k] = 32'd0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", {out_valid, out_illegal, out_addr}, 34'd0);
    chk("R9", {33'd0, in_ready}, 34'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", {out_valid, out_illegal, out_addr}, 34'd0);

    // sweep: every mode / enable / select / scale / combine / disp-width combination
    prev_exp = '0; prev_tag = "";
    for (int v = 0; v < 8192; v++) begin
      @(negedge clk);
      if (v > 0) chk(prev_tag, {out_valid, out_illegal, out_addr}, {1'b1, prev_exp});
      for (int k = 0; k < 8; k++) rf[k] = mix(32'(v), 32'(k));
      drive(v[12], v[1], v[11], v[9:7], v[10], v[6:4], v[3:2], v[0], mix(32'(v), 32'd9));
      in_valid = 1'b1;
      prev_exp = model();
      prev_tag = pick_tag(prev_exp);
    end
    @(negedge clk);
    chk(prev_tag, {out_valid, out_illegal, out_addr}, {1'b1, prev_exp});
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10", {33'd0, out_valid}, 34'd0);

    // R1: wrap-around of the wide sum
    rf[1] = 32'hFFFF_FFF0; rf[2] = 32'h0000_0004;
    drive(1'b1, 1'b0, 1'b1, 3'd1, 1'b1, 3'd2, 2'd3, 1'b0, 32'h0000_0010);
    in_valid = 1'b1;
    @(negedge clk);
    chk("R1", {out_valid, out_illegal, out_addr}, {2'b10, 32'h0000_0020});
    in_valid = 1'b0;
    @(negedge clk);

    // R9 / R10: stall holds the result and blocks the next request
    out_ready = 1'b0;
    rf[1] = 32'h0000_1000; rf[2] = 32'h0000_0030; rf[3] = 32'h0001_2345; rf[6] = 32'h0000_0100;
    drive(1'b1, 1'b0, 1'b1, 3'd1, 1'b1, 3'd2, 2'd1, 1'b1, 32'h0000_0007);
    exp_a = model();
    in_valid = 1'b1;
    @(negedge clk);
    chk("R10", {out_valid, out_illegal, out_addr}, {1'b1, exp_a});
    chk("R9", {33'd0, in_ready}, 34'd0);
    drive(1'b0, 1'b1, 1'b1, 3'd3, 1'b1, 3'd6, 2'd2, 1'b0, 32'h0000_00FE);
    exp_b = model();
    for (int w = 0; w < 3; w++) begin
      @(negedge clk);
      chk("R9", {out_valid, out_illegal, out_addr}, {1'b1, exp_a});
      chk("R9", {33'd0, in_ready}, 34'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9", {out_valid, out_illegal, out_addr}, {1'b1, exp_b});
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10", {33'd0, out_valid}, 34'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule